// File: doc/BRIEF.md
# Multi-Channel Prescaled PWM Timer

This block produces edge-aligned pulse-width-modulated outputs on a parameterised number of channels from one shared 16-bit up-counter. The counter is paced by a power-of-two prescaler. It runs from zero up to a programmable modulo value and then starts again at zero, so the modulo sets the PWM period. Each channel holds a compare threshold and a small control field. Together these choose whether the output is off, follows the counter normally, or follows it inverted.

Software drives the block through a word-addressed register port that has a write strobe and a combinational read path. Modulo and compare writes go first into shadow copies. While the counter runs, those copies become active only at the wrap from the modulo value back to zero, so a period never mixes old and new settings. While the counter is stopped, they become active on the next clock. Each channel also has an event flag that records a compare match and is cleared by writing a one to it.

Top module: `pwm_timer`

## Requirements
- R1: Offset 0x04 reads the implemented channel count in bits 7:0, and offset 0x08 reads zero. Channel offsets at or beyond the channel count read zero and ignore writes.
- R2: The control register at 0x10 stores prescale in bits 2:0, clock mode in bits 4:3 and the center-select bit in bit 5, and reads them back. The center-select bit has no effect on counting or outputs.
- R3: With clock mode 1, the counter at 0x14 advances once every 2^prescale clocks, counts 0..modulo, and returns to 0 after the modulo value. A full period lasts (modulo+1)·2^prescale clocks.
- R4: With any clock mode other than 1, the counter holds its value.
- R5: Any write to offset 0x14 clears the counter to 0.
- R6: While the counter runs, a write to the modulo (0x18) or to a channel compare value (0x24+8n) reads back as the old value until the next wrap, and as the new value afterwards.
- R7: While the counter is stopped, a written modulo or compare value is active, and reads back, from the next clock.
- R8: A channel whose control (0x20+8n) has bit 5 = 1 and bits 3:2 = 2 drives its output high while counter < compare. A compare above the modulo therefore gives a constant high, and a compare of 0 gives a constant low.
- R9: With bit 5 = 1 and bits 3:2 = 1, the output is the complement of the R8 output.
- R10: With bits 3:2 = 0, or with bit 5 = 0, the channel output is low.
- R11: A channel's event flag (control bit 7) is set when the counter advances from a value equal to that channel's compare value. Writing 1 to bit 7 clears the flag, and writing 0 to it leaves the flag unchanged.
- R12: After reset the counter is 0, the modulo is 0xFFFF, compare values and control fields are 0, the counter is stopped, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the accessed register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data for `addr` |
| pwmOut | output | NCH | Per-channel PWM outputs |

## Verification
The bench builds the block with two channels, so the out-of-range channel offset sits right after the last real one. Prescale values 0 through 3 are swept across several small modulo values, with compare values of zero, a middle value, exactly the modulo, and one past it. Keeping every period at 104 clocks or fewer allows each configuration's high-time to be counted over a full period and compared with cv·2^ps. The normal and inverted channels run side by side, and the flag outcome is checked for every combination.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  localparam int CNT_W = 16;

  localparam logic [7:0] OFS_INFO   = 8'h04;
  localparam logic [7:0] OFS_GLOBAL = 8'h08;
  localparam logic [7:0] OFS_CTL    = 8'h10;
  localparam logic [7:0] OFS_CNT    = 8'h14;
  localparam logic [7:0] OFS_MOD    = 8'h18;
  localparam logic [7:0] OFS_CHBASE = 8'h20;

  localparam logic [1:0] LVL_OFF  = 2'd0;
  localparam logic [1:0] LVL_INV  = 2'd1;
  localparam logic [1:0] LVL_NORM = 2'd2;
  localparam logic [1:0] CLKM_RUN = 2'd1;

  typedef enum logic [2:0] {
    WK_NONE,
    WK_CNT,
    WK_MOD,
    WK_CV,
    WK_CHCTL
  } wrKind_e;

  typedef struct packed {
    wrKind_e          kind;
    logic [7:0]       ch;
    logic [CNT_W-1:0] data;
  } wrStrobe_t;
endpackage

// File: rtl/pwm_timer_shadow.sv
module pwm_timer_shadow #(
  parameter int W = 16,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wr,
  input  logic [W-1:0] wrData,
  input  logic         loadOk,
  output logic [W-1:0] act
);
  logic [W-1:0] sh;
  logic         pend;
  logic         load;

  assign load = pend && loadOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh   <= RST_VAL;
      pend <= 1'b0;
      act  <= RST_VAL;
    end else begin
      if (wr) begin
        sh   <= wrData;
        pend <= 1'b1;
      end else if (load) begin
        pend <= 1'b0;
      end
      if (load) act <= sh;
    end
  end

  AST_HELD_UNTIL_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    !loadOk |=> $stable(act)); // R6

  AST_PENDING_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (pend && loadOk) |=> (act == $past(sh))); // R7
endmodule

// File: rtl/pwm_timer_dp.sv
module pwm_timer_dp
  import pwm_timer_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int PS_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PS_W-1:0]  ps,
  input  logic             running,
  input  wrStrobe_t        strobe,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] modAct,
  output logic [CNT_W-1:0] cvAct [NCH],
  output logic [1:0]       chLvl [NCH],
  output logic             chMsa [NCH],
  output logic             chMsb [NCH],
  output logic             chFlag [NCH],
  output logic [NCH-1:0]   pwmOut
);
  localparam int PRE_W = (1 << PS_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic [PRE_W:0]   preOne;
  logic             tick;
  logic             wrapEv;
  logic             cntClr;
  logic             loadOk;

  assign preOne  = (PRE_W + 1)'(1) << ps;
  assign preMask = PRE_W'(preOne - 1'b1);
  assign tick    = running && ((preCnt & preMask) == preMask);
  assign wrapEv  = tick && (cnt >= modAct);
  assign cntClr  = (strobe.kind == WK_CNT);
  assign loadOk  = !running || wrapEv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
    end else begin
      if (!running || cntClr) preCnt <= '0;
      else                    preCnt <= preCnt + 1'b1;
      if (cntClr)      cnt <= '0;
      else if (wrapEv) cnt <= '0;
      else if (tick)   cnt <= cnt + 1'b1;
    end
  end

  pwm_timer_shadow #(.W(CNT_W), .RST_VAL({CNT_W{1'b1}})) u_modSh (
    .clk    (clk),
    .rstN   (rstN),
    .wr     (strobe.kind == WK_MOD),
    .wrData (strobe.data),
    .loadOk (loadOk),
    .act    (modAct)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic chSel;
    logic below;
    logic flagSet;
    logic flagClr;

    assign chSel   = (strobe.ch == 8'(i));
    assign below   = (cnt < cvAct[i]);
    assign flagSet = tick && (cnt == cvAct[i]);
    assign flagClr = (strobe.kind == WK_CHCTL) && chSel && strobe.data[7];

    pwm_timer_shadow #(.W(CNT_W), .RST_VAL('0)) u_cvSh (
      .clk    (clk),
      .rstN   (rstN),
      .wr     ((strobe.kind == WK_CV) && chSel),
      .wrData (strobe.data),
      .loadOk (loadOk),
      .act    (cvAct[i])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chLvl[i]  <= LVL_OFF;
        chMsa[i]  <= 1'b0;
        chMsb[i]  <= 1'b0;
        chFlag[i] <= 1'b0;
      end else begin
        if ((strobe.kind == WK_CHCTL) && chSel) begin
          chLvl[i] <= strobe.data[3:2];
          chMsa[i] <= strobe.data[4];
          chMsb[i] <= strobe.data[5];
        end
        chFlag[i] <= flagSet || (chFlag[i] && !flagClr);
      end
    end

    always_comb begin
      pwmOut[i] = 1'b0;
      if (chMsb[i]) begin
        case (chLvl[i])
          LVL_NORM: pwmOut[i] = below;
          LVL_INV:  pwmOut[i] = !below;
          default:  pwmOut[i] = 1'b0;
        endcase
      end
    end

    AST_FLAG_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
      flagSet |=> chFlag[i]); // R11
  end

  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    wrapEv |=> (cnt == '0)); // R3

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !cntClr) |=> $stable(cnt)); // R4

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    cntClr |=> (cnt == '0)); // R5
endmodule

// File: rtl/pwm_timer_ctrl.sv
module pwm_timer_ctrl
  import pwm_timer_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [PS_W-1:0]   ps,
  output logic              running,
  output wrStrobe_t         strobe,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [CNT_W-1:0]  modAct,
  input  logic [CNT_W-1:0]  cvAct [NCH],
  input  logic [1:0]        chLvl [NCH],
  input  logic              chMsa [NCH],
  input  logic              chMsb [NCH],
  input  logic              chFlag [NCH]
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int SLOT_W = ADDR_W - 3;
  localparam logic [SLOT_W-1:0] NCH_L = SLOT_W'(NCH);

  logic [1:0]        clkMode;
  logic              centerSel;
  logic [ADDR_W-1:0] chOfs;
  logic [SLOT_W-1:0] slot;
  logic [IDX_W-1:0]  idx;
  logic              isCh;
  logic              isCv;

  assign chOfs = addr - ADDR_W'(OFS_CHBASE);
  assign slot  = chOfs[ADDR_W-1:3];
  assign idx   = slot[IDX_W-1:0];
  assign isCv  = chOfs[2];
  assign isCh  = (addr >= ADDR_W'(OFS_CHBASE)) && (slot < NCH_L) && (chOfs[1:0] == 2'b00);
  assign running = (clkMode == CLKM_RUN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ps        <= '0;
      clkMode   <= '0;
      centerSel <= 1'b0;
    end else if (wrEn && (addr == ADDR_W'(OFS_CTL))) begin
      ps        <= wrData[PS_W-1:0];
      clkMode   <= wrData[PS_W+1:PS_W];
      centerSel <= wrData[PS_W+2];
    end
  end

  always_comb begin
    strobe.kind = WK_NONE;
    strobe.ch   = 8'(slot);
    strobe.data = wrData;
    if (wrEn) begin
      if (addr == ADDR_W'(OFS_CNT))      strobe.kind = WK_CNT;
      else if (addr == ADDR_W'(OFS_MOD)) strobe.kind = WK_MOD;
      else if (isCh)                     strobe.kind = isCv ? WK_CV : WK_CHCTL;
    end
  end

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(OFS_INFO))        rdData = CNT_W'(NCH[7:0]);
    else if (addr == ADDR_W'(OFS_GLOBAL)) rdData = '0;
    else if (addr == ADDR_W'(OFS_CTL))    rdData = CNT_W'({centerSel, clkMode, ps});
    else if (addr == ADDR_W'(OFS_CNT))    rdData = cnt;
    else if (addr == ADDR_W'(OFS_MOD))    rdData = modAct;
    else if (isCh) begin
      if (isCv) rdData = cvAct[idx];
      else rdData = CNT_W'({chFlag[idx], 1'b0, chMsb[idx], chMsa[idx], chLvl[idx], 2'b00});
    end
  end

  AST_CH_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ((strobe.kind == WK_CV) || (strobe.kind == WK_CHCTL)) |-> (strobe.ch < 8'(NCH))); // R1
endmodule

// File: rtl/pwm_timer.sv
module pwm_timer
  import pwm_timer_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int PS_W   = 3,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic [NCH-1:0]    pwmOut
);
  logic [PS_W-1:0]  ps;
  logic             running;
  wrStrobe_t        strobe;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] modAct;
  logic [CNT_W-1:0] cvAct [NCH];
  logic [1:0]       chLvl [NCH];
  logic             chMsa [NCH];
  logic             chMsb [NCH];
  logic             chFlag [NCH];

  pwm_timer_ctrl #(.NCH(NCH), .PS_W(PS_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .ps      (ps),
    .running (running),
    .strobe  (strobe),
    .cnt     (cnt),
    .modAct  (modAct),
    .cvAct   (cvAct),
    .chLvl   (chLvl),
    .chMsa   (chMsa),
    .chMsb   (chMsb),
    .chFlag  (chFlag)
  );

  pwm_timer_dp #(.NCH(NCH), .PS_W(PS_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ps      (ps),
    .running (running),
    .strobe  (strobe),
    .cnt     (cnt),
    .modAct  (modAct),
    .cvAct   (cvAct),
    .chLvl   (chLvl),
    .chMsa   (chMsa),
    .chMsb   (chMsb),
    .chFlag  (chFlag),
    .pwmOut  (pwmOut)
  );
endmodule

// File: tb/pwm_timer_tb.sv
`timescale 1ns/1ps
module pwm_timer_tb;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [15:0] wrData = 16'h0;
  logic [15:0] rdData;
  logic [NCH-1:0] pwmOut;

  int nChecks = 0;
  int nFails = 0;
  logic [15:0] rv;
  logic [15:0] rv2;

  always #10 clk = ~clk;

  pwm_timer #(.NCH(NCH)) u_dut (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addr   (addr),
    .wrData (wrData),
    .rdData (rdData),
    .pwmOut (pwmOut)
  );

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdData;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  initial begin
    #4000000;
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    int hi0;
    int hi1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R12 reset state
    rd(8'h14, rv); chk("R12 counter", rv == 0, rv, 0);
    rd(8'h18, rv); chk("R12 modulo", rv == 16'hFFFF, rv, 16'hFFFF);
    rd(8'h10, rv); chk("R12 control", rv == 0, rv, 0);
    rd(8'h24, rv); chk("R12 compare", rv == 0, rv, 0);
    chk("R12 outputs", pwmOut == 0, pwmOut, 0);

    // R1 info, global, out-of-range channel
    rd(8'h04, rv); chk("R1 channel count", rv == NCH, rv, NCH);
    rd(8'h08, rv); chk("R1 global", rv == 0, rv, 0);
    wr(8'h30, 16'h0028); rd(8'h30, rv); chk("R1 absent channel ctl", rv == 0, rv, 0);
    wr(8'h34, 16'h0005); rd(8'h34, rv); chk("R1 absent channel cv", rv == 0, rv, 0);

    // R2 control readback with center select; clock mode stop
    wr(8'h10, 16'h0025); rd(8'h10, rv); chk("R2 readback", rv == 16'h0025, rv, 16'h25);
    rd(8'h14, rv); idle(20); rd(8'h14, rv2);
    chk("R4 stopped holds", rv == rv2, rv2, rv);

    // Main sweep: R3, R8, R9, R11
    for (int p = 0; p < 4; p++) begin
      for (int mi = 0; mi < 3; mi++) begin
        for (int ci = 0; ci < 4; ci++) begin
          int m;
          int cv;
          int per;
          int expHi;
          m   = (mi == 0) ? 3 : (mi == 1) ? 7 : 12;
          cv  = (ci == 0) ? 0 : (ci == 1) ? 2 : (ci == 2) ? m : m + 1;
          per = (m + 1) << p;
          expHi = ((cv > m + 1) ? (m + 1) : cv) << p;
          wr(8'h10, 16'(p));
          wr(8'h14, 16'h0);
          wr(8'h20, 16'h00A8);
          wr(8'h28, 16'h00A4);
          rd(8'h20, rv); chk("R11 clear by one", rv[7] == 1'b0, rv[7], 0);
          wr(8'h18, 16'(m));
          wr(8'h24, 16'(cv));
          wr(8'h2C, 16'(cv));
          rd(8'h18, rv); chk("R7 stopped load", rv == 16'(m), rv, m);
          wr(8'h10, 16'(p | 8));
          idle(2 * per);
          rd(8'h14, rv); chk("R3 counter within modulo", rv <= 16'(m), rv, m);
          hi0 = 0; hi1 = 0;
          for (int k = 0; k < per; k++) begin
            @(negedge clk);
            hi0 += int'(pwmOut[0]);
            hi1 += int'(pwmOut[1]);
          end
          chk("R8 normal high time", hi0 == expHi, hi0, expHi);
          chk("R9 inverted high time", hi1 == per - expHi, hi1, per - expHi);
          wr(8'h10, 16'(p));
          rd(8'h20, rv); chk("R11 flag on match", rv[7] == (cv <= m), rv[7], int'(cv <= m));
          wr(8'h20, 16'h0028);
          rd(8'h20, rv); chk("R11 zero write keeps flag", rv[7] == (cv <= m), rv[7], int'(cv <= m));
        end
      end
    end

    // R5 counter clear
    wr(8'h18, 16'd50); wr(8'h10, 16'h0008); idle(30); wr(8'h10, 16'h0000);
    rd(8'h14, rv); chk("R5 nonzero before clear", rv != 0, rv, 1);
    wr(8'h14, 16'h1234); rd(8'h14, rv); chk("R5 cleared", rv == 0, rv, 0);

    // R6 buffered updates while running
    wr(8'h18, 16'd100); wr(8'h24, 16'd30); wr(8'h14, 16'h0);
    wr(8'h10, 16'h0008);
    idle(5);
    wr(8'h18, 16'd40); wr(8'h24, 16'd10);
    rd(8'h18, rv); chk("R6 modulo old", rv == 100, rv, 100);
    rd(8'h24, rv); chk("R6 compare old", rv == 30, rv, 30);
    idle(200);
    rd(8'h18, rv); chk("R6 modulo new", rv == 40, rv, 40);
    rd(8'h24, rv); chk("R6 compare new", rv == 10, rv, 10);
    rd(8'h14, rv); chk("R3 within new modulo", rv <= 40, rv, 40);

    // R10 disabled outputs
    wr(8'h20, 16'h0020);
    hi0 = 0;
    for (int k = 0; k < 82; k++) begin @(negedge clk); hi0 += int'(pwmOut[0]); end
    chk("R10 level off low", hi0 == 0, hi0, 0);
    wr(8'h20, 16'h0008);
    hi0 = 0;
    for (int k = 0; k < 82; k++) begin @(negedge clk); hi0 += int'(pwmOut[0]); end
    chk("R10 mode bit clear low", hi0 == 0, hi0, 0);
    wr(8'h20, 16'h0028);
    hi0 = 0;
    for (int k = 0; k < 41; k++) begin @(negedge clk); hi0 += int'(pwmOut[0]); end
    chk("R8 after re-enable", hi0 == 10, hi0, 10);

    // R2 center select has no effect
    wr(8'h10, 16'h0028);
    hi0 = 0;
    for (int k = 0; k < 41; k++) begin @(negedge clk); hi0 += int'(pwmOut[0]); end
    chk("R2 center select inert", hi0 == 10, hi0, 10);

    // R4 other clock mode stops
    wr(8'h10, 16'h0010);
    rd(8'h14, rv); idle(15); rd(8'h14, rv2);
    chk("R4 mode two holds", rv == rv2, rv2, rv);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule